// File: doc/BRIEF.md
# Fast UART Receive Queue with Interrupt Flags

This block holds the receive path of a fast memory-mapped UART between the bit-level deserializer and software. Each character from the deserializer arrives with two tags: a framing-error tag and a break tag. The block stores the character and its tags in a 64-deep queue. Software reads the queue through a 32-bit register port. Each read returns the character, its tags, and a flag that says whether the queue had nothing to give.

The block also reports how full the queue is. It keeps five interrupt sources:
- a fill-threshold condition;
- an idle-line timeout measured in character times;
- framing, break and overrun latches.

The error latches are cleared by writing ones to them. Two enable bits in the control register gate the sources onto a single interrupt line. A separate character-time strobe from the baud generator clocks the idle timeout. The transmit side supplies its fill count, and the block only reflects that count in the level register.

Top module: `hsu_rx_core`

## Requirements
- R1: After reset the level register reads 0, the status register reads 0, `irq_o` is low, and a queue read returns 0x100.
- R2: A queue read at offset 0x00 pops the oldest character. The returned word has the character in bits 7:0, its framing tag in bit 9 and its break tag in bit 10. Characters come out in arrival order.
- R3: The level register at offset 0x04 shows the receive count in bits 7:0 and `tx_level_i` in bits 15:8. The count is updated in the cycle after each push or pop.
- R4: A read of the empty queue returns bit 8 set with zero data and tags. It leaves the read pointer unchanged, so later characters still come out correctly.
- R5: Status bit 1 is high while the receive count is at least the threshold selected by control bits 4:2. Code 0 selects 1 character, 1 selects 4, 2 selects 8, 3 selects 16 and 4 selects 32. Codes 5 to 7 select 48. The bit falls as soon as the count drops below the threshold.
- R6: Control bits 17:16 select the idle timeout: 0 disables it, and 1, 2 and 3 select 4, 8 and 16 character strobes. Status bit 2 sets on the strobe that reaches the limit while the queue is non-empty. Any push or pop restarts the count and clears the bit.
- R7: A character that arrives while 64 entries are held is dropped and sets status bit 5. The count stays at 64.
- R8: An accepted character with its framing tag sets status bit 3. An accepted character with its break tag sets status bit 4.
- R9: Writing offset 0x08 clears each of status bits 2 to 5 whose write-data bit is 1. Zero bits leave their flags unchanged.
- R10: `irq_o` is high when control bit 6 is set and status bit 1 or 2 is set. It is also high when control bit 7 is set and any of status bits 3 to 5 is set. Otherwise it is low.
- R11: The control register at offset 0x0C reads back bits 4:2, 6, 7 and 17:16 as written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a character is ready from the deserializer |
| rx_data_i | input | 8 | Received character |
| rx_ferr_i | input | 1 | Framing-error tag for the character |
| rx_brk_i | input | 1 | Break tag for the character |
| char_tick_i | input | 1 | One pulse per character time |
| tx_level_i | input | 8 | Transmit fill count, reflected in the level register |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request |

## Verification
Embedded assertions check on every cycle that the count never passes 64 and that a push into a full queue leaves it full and raises the overrun flag. They also check that a read of the empty queue moves no pointer and that the idle flag is never up while the queue is empty. Directed scenarios are needed for the rest:
- the data and tag layout of a read word and the order of characters;
- each threshold code and each timeout code, including the restart on a push or pop;
- the write-one clear;
- the gating of the interrupt line by each enable.

// File: rtl/hsu_rx_pkg.sv
package hsu_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  localparam logic [4:0] OFF_QUEUE = 5'h00;
  localparam logic [4:0] OFF_LEVEL = 5'h04;
  localparam logic [4:0] OFF_STAT  = 5'h08;
  localparam logic [4:0] OFF_CTRL  = 5'h0C;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic [CHAR_W-1:0] ch;
  } rx_ent_t;

  function automatic logic [7:0] trig_thresh(input logic [2:0] sel);
    case (sel)
      3'd0:    return 8'd1;
      3'd1:    return 8'd4;
      3'd2:    return 8'd8;
      3'd3:    return 8'd16;
      3'd4:    return 8'd32;
      default: return 8'd48;
    endcase
  endfunction

  function automatic logic [4:0] idle_limit(input logic [1:0] sel);
    case (sel)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/hsu_rx_fifo.sv
module hsu_rx_fifo
  import hsu_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_ent_t       din_i,
  input  logic          pop_i,
  output rx_ent_t       dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  rx_ent_t       mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_stays_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
  assert_empty_read_safe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (empty_o && $stable(rd_ptr_q)));
endmodule

// File: rtl/hsu_rx_idle.sv
module hsu_rx_idle
  import hsu_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       active_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic [4:0] cnt_q;
  logic [4:0] limit;
  logic       flag_q;

  assign limit  = idle_limit(sel_i);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (restart_i || clr_i || !active_i || limit == '0) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (tick_i && !flag_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 5'd1 >= limit) flag_q <= 1'b1;
    end
  end

  assert_idle_needs_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> active_i);
  assert_idle_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !flag_o);
endmodule

// File: rtl/hsu_rx_errflags.sv
module hsu_rx_errflags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
  end
endmodule

// File: rtl/hsu_rx_core.sv
module hsu_rx_core
  import hsu_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_ferr_i,
  input  logic        rx_brk_i,
  input  logic        char_tick_i,
  input  logic [7:0]  tx_level_i,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic [2:0]    trig_sel_q;
  logic [1:0]    idle_sel_q;
  logic          rx_ie_q, err_ie_q;
  rx_ent_t       din, dout;
  logic [CW-1:0] count;
  logic          empty, full, pop, wr_stat, wr_ctrl;
  logic          trig, idle;
  logic [2:0]    err_set, err_clr, err_q;  // {oe, brk, fe}

  assign pop     = reg_req_i && !reg_we_i && reg_addr_i == OFF_QUEUE;
  assign wr_stat = reg_req_i && reg_we_i && reg_addr_i == OFF_STAT;
  assign wr_ctrl = reg_req_i && reg_we_i && reg_addr_i == OFF_CTRL;
  assign din     = '{brk: rx_brk_i, fe: rx_ferr_i, ch: rx_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_sel_q <= '0;
      idle_sel_q <= '0;
      rx_ie_q    <= 1'b0;
      err_ie_q   <= 1'b0;
    end else if (wr_ctrl) begin
      trig_sel_q <= reg_wdata_i[4:2];
      rx_ie_q    <= reg_wdata_i[6];
      err_ie_q   <= reg_wdata_i[7];
      idle_sel_q <= reg_wdata_i[17:16];
    end
  end

  hsu_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_valid_i),
    .din_i  (din),
    .pop_i  (pop),
    .dout_o (dout),
    .count_o(count),
    .empty_o(empty),
    .full_o (full)
  );

  hsu_rx_idle u_idle (
    .clk_i, .rst_ni,
    .tick_i   (char_tick_i),
    .active_i (!empty),
    .restart_i((rx_valid_i && !full) || (pop && !empty)),
    .sel_i    (idle_sel_q),
    .clr_i    (wr_stat && reg_wdata_i[2]),
    .flag_o   (idle)
  );

  assign err_set = {rx_valid_i && full,
                    rx_valid_i && !full && rx_brk_i,
                    rx_valid_i && !full && rx_ferr_i};
  assign err_clr = {3{wr_stat}} & reg_wdata_i[5:3];

  hsu_rx_errflags #(.N(3)) u_err (
    .clk_i, .rst_ni,
    .set_i (err_set),
    .clr_i (err_clr),
    .flag_o(err_q)
  );

  assign trig  = 8'(count) >= trig_thresh(trig_sel_q);
  assign irq_o = (rx_ie_q && (trig || idle)) || (err_ie_q && |err_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_QUEUE: reg_rdata_o[10:0] = empty ? 11'h100
                                           : {dout.brk, dout.fe, 1'b0, dout.ch};
      OFF_LEVEL: reg_rdata_o[15:0] = {tx_level_i, 8'(count)};
      OFF_STAT:  reg_rdata_o[5:1]  = {err_q, idle, trig};
      OFF_CTRL: begin
        reg_rdata_o[4:2]   = trig_sel_q;
        reg_rdata_o[6]     = rx_ie_q;
        reg_rdata_o[7]     = err_ie_q;
        reg_rdata_o[17:16] = idle_sel_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assert_overrun_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && full) |=> err_q[2]);
  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ie_q && !err_ie_q) |-> !irq_o);
endmodule

// File: tb/sim_hsu_rx_core.sv
module sim_hsu_rx_core;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_valid = 0, rx_ferr = 0, rx_brk = 0, tick = 0;
  logic [7:0]  rx_data = 0, tx_level = 0;
  logic        req = 0, we = 0;
  logic [4:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  hsu_rx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk), .char_tick_i(tick),
    .tx_level_i(tx_level), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic fe = 0, logic bk = 0);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_ferr = fe; rx_brk = bk;
    @(posedge clk); #1 rx_valid = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 v = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] v);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = v;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic drain(int n);
    logic [31:0] v;
    for (int i = 0; i < n; i++) rd(5'h00, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h04, v); check("R1 level", v, 0);
    rd(5'h08, v); check("R1 status", v, 0);
    @(negedge clk); check("R1 irq", {31'b0, irq}, 0);
    rd(5'h00, v); check("R1 queue", v, 32'h100);
  endtask

  task automatic t_format;
    logic [31:0] v;
    tx_level = 8'h2A;
    push(8'hA5, 1, 0); push(8'h3C, 0, 1); push(8'h7E);
    rd(5'h04, v); check("R3 level", v, 32'h2A03);
    rd(5'h00, v); check("R2 fe word", v, 32'h2A5);
    rd(5'h00, v); check("R2 brk word", v, 32'h43C);
    rd(5'h00, v); check("R2 plain word", v, 32'h07E);
    rd(5'h04, v); check("R3 level drained", v, 32'h2A00);
    rd(5'h08, v); check("R8 fe+brk flags", v, 32'h18);
    wr(5'h08, 32'h08);
    rd(5'h08, v); check("R9 clear fe", v, 32'h10);
    wr(5'h08, 32'h00);
    rd(5'h08, v); check("R9 zero write", v, 32'h10);
    wr(5'h08, 32'h10);
    rd(5'h08, v); check("R9 clear brk", v, 0);
    tx_level = 0;
  endtask

  task automatic t_empty_read;
    logic [31:0] v;
    rd(5'h00, v); check("R4 empty 1", v, 32'h100);
    rd(5'h00, v); check("R4 empty 2", v, 32'h100);
    push(8'h11);
    rd(5'h00, v); check("R4 after underflow try", v, 32'h011);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    int thr [6] = '{1, 4, 8, 16, 32, 48};
    for (int s = 0; s < 6; s++) begin
      wr(5'h0C, 32'(s) << 2);
      for (int i = 0; i < thr[s] - 1; i++) push(8'(i));
      rd(5'h08, v); check("R5 below thr", v & 32'h2, 0);
      push(8'hEE);
      rd(5'h08, v); check("R5 at thr", v & 32'h2, 32'h2);
      drain(1);
      rd(5'h08, v); check("R5 fell", v & 32'h2, 0);
      drain(thr[s] - 1);
    end
    wr(5'h0C, 0);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    wr(5'h0C, 32'h1_0000);
    push(8'h55);
    ticks(3); rd(5'h08, v); check("R6 before 4", v & 32'h4, 0);
    ticks(1); rd(5'h08, v); check("R6 at 4", v & 32'h4, 32'h4);
    wr(5'h08, 32'h4);
    rd(5'h08, v); check("R9 clear idle", v & 32'h4, 0);
    wr(5'h0C, 32'h2_0000);
    ticks(5); push(8'h66); ticks(5);
    rd(5'h08, v); check("R6 restart on push", v & 32'h4, 0);
    ticks(3); rd(5'h08, v); check("R6 at 8", v & 32'h4, 32'h4);
    drain(1);
    rd(5'h08, v); check("R6 pop clears", v & 32'h4, 0);
    wr(5'h0C, 32'h0);
    ticks(20); rd(5'h08, v); check("R6 disabled", v & 32'h4, 0);
    drain(1);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    int bad = 0;
    wr(5'h0C, 32'h14);
    for (int i = 0; i < 64; i++) push(8'(i));
    rd(5'h04, v); check("R7 full level", v, 64);
    rd(5'h08, v); check("R7 no oe yet", v & 32'h20, 0);
    push(8'hFF);
    rd(5'h08, v); check("R7 oe set", v & 32'h20, 32'h20);
    rd(5'h04, v); check("R7 level held", v, 64);
    for (int i = 0; i < 64; i++) begin
      rd(5'h00, v);
      if (v !== 32'(i)) bad++;
    end
    check("R7 order kept, drop of extra", 32'(bad), 0);
    rd(5'h00, v); check("R7 extra dropped", v, 32'h100);
  endtask

  task automatic t_irq;
    wr(5'h0C, 32'h0);
    @(negedge clk); check("R10 masked", {31'b0, irq}, 0);
    wr(5'h0C, 32'h80);
    @(negedge clk); check("R10 err enable", {31'b0, irq}, 1);
    wr(5'h08, 32'h20);
    @(negedge clk); check("R10 oe cleared", {31'b0, irq}, 0);
    wr(5'h0C, 32'h40);
    push(8'h01);
    @(negedge clk); check("R10 rx enable trig", {31'b0, irq}, 1);
    wr(5'h0C, 32'h0);
    @(negedge clk); check("R10 rx disable", {31'b0, irq}, 0);
    drain(1);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); check("R11 readback", v, 32'h3_00DC);
    wr(5'h0C, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_format();
    t_empty_read();
    t_trigger();
    t_idle();
    t_overrun();
    t_irq();
    t_ctrl();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule